// File: doc/BRIEF.md
# Move-Operand Address Generator

This block computes, in one step, the source and destination operand addresses of a data-move operation. It owns a file of sixteen 16-bit working registers. A request names an addressing mode and a pointer register for each side, one offset-register number that either side may use, a signed literal offset, a byte/word size flag and an optional immediate source. The block reads the pointers and the offset register and forms both addresses. It also applies every pointer update to its own register file and reports each update as an enable, a register number and a value.

Requests arrive on a valid/ready input and results leave on a valid/ready output that holds one entry. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high when the output slot is empty or is being emptied in the same cycle, so back-pressure on `rsp_ready` stalls the input. A held result stays stable until it is taken. Pointer updates reach the register file in the cycle the request is taken, so a request taken in the next cycle already sees them. A separate write port lets the arithmetic datapath load registers.

Top module: `move_ea_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and every working register reads as 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is 0 only while `rsp_valid` is 1 and `rsp_ready` is 0. While a result is held, all response outputs stay stable.
- R3: Mode code 0 (register direct) returns the register's contents as that side's address, sets that side's direct flag and writes nothing back.
- R4: Mode code 1 (indirect) returns the pointer value and writes nothing back.
- R5: Mode codes 2 and 3 (post-increment and post-decrement) return the old pointer and write back the pointer plus or minus the step. The step is 1 when `req_byte` is 1 and 2 otherwise.
- R6: Mode codes 4 and 5 (pre-increment and pre-decrement) update the pointer by the step and return the new value, which is also written back.
- R7: Mode code 6 (indexed) returns the pointer plus the register named by the shared `req_ofs_reg` field and writes nothing back. Either side may use this field, and both sides may use it in the same request.
- R8: Mode code 7 (literal offset) returns the pointer plus the sign-extended `req_lit` and writes nothing back.
- R9: When `req_imm_kind` is 1, the source address is `{8'h00, req_imm[7:0]}`. When it is 2 or 3, the source address is `req_imm`. In both cases `rsp_src_imm` is 1, the source direct flag is 0 and the source writes nothing back. The destination is unaffected. When `req_imm_kind` is 0, the source uses its mode.
- R10: When both sides write back the same register, only the destination update is reported and applied.
- R11: Pointer updates are applied to the register file when the request is taken. A request taken in the next cycle sees the updated values.
- R12: `rf_we` writes `rf_wdata` into register `rf_waddr`. If a pointer update targets the same register in the same cycle, the pointer update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_src_mode | input | 3 | Source mode code |
| req_src_reg | input | 4 | Source pointer register |
| req_dst_mode | input | 3 | Destination mode code |
| req_dst_reg | input | 4 | Destination pointer register |
| req_ofs_reg | input | 4 | Shared offset register number |
| req_lit | input | 10 | Signed literal offset |
| req_byte | input | 1 | 1 for a byte access, 0 for a word access |
| req_imm_kind | input | 2 | 0 none, 1 8-bit immediate, 2 or 3 16-bit immediate |
| req_imm | input | 16 | Immediate value |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 4 | Register file write index |
| rf_wdata | input | 16 | Register file write data |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_src_ea | output | 16 | Source address, register value or immediate |
| rsp_dst_ea | output | 16 | Destination address or register value |
| rsp_src_direct | output | 1 | Source is register direct |
| rsp_dst_direct | output | 1 | Destination is register direct |
| rsp_src_imm | output | 1 | Source is an immediate |
| rsp_wb_src_en | output | 1 | Source pointer update applied |
| rsp_wb_src_reg | output | 4 | Source pointer update register |
| rsp_wb_src_val | output | 16 | Source pointer update value |
| rsp_wb_dst_en | output | 1 | Destination pointer update applied |
| rsp_wb_dst_reg | output | 4 | Destination pointer update register |
| rsp_wb_dst_val | output | 16 | Destination pointer update value |

## Verification
The assertions assume that request fields are known (not X) from reset onward, and that the bench drives each field to a defined value even while `req_valid` is low. They also assume that `rsp_ready` changes only between clock edges. The stimulus drives every input at the falling edge and parks idle fields at zero. It draws mode codes, register numbers, literals and immediate kinds from seeded `$urandom` over their full ranges, so same-register conflicts and shared-offset use occur naturally. Directed cases add the conflict, back-to-back pointer reuse and write-port collisions.

// File: rtl/move_ea_pkg.sv
package move_ea_pkg;
  localparam int unsigned DW = 16;

  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_POSTINC = 3'd2,
    AM_POSTDEC = 3'd3,
    AM_PREINC  = 3'd4,
    AM_PREDEC  = 3'd5,
    AM_INDEXED = 3'd6,
    AM_LITOFS  = 3'd7
  } amode_e;

  typedef struct packed {
    logic [DW-1:0] ea;
    logic          direct;
    logic          wb_en;
    logic [DW-1:0] wb_val;
  } side_res_t;
endpackage

// File: rtl/ea_side.sv
module ea_side
  import move_ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  amode_e        mode,
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] ofs,
  input  logic [DW-1:0] lit_sx,
  input  logic          is_byte,
  output side_res_t     res
);
  logic [DW-1:0] step;
  logic [DW-1:0] ptr_up;
  logic [DW-1:0] ptr_dn;

  assign step   = is_byte ? DW'(1) : DW'(2);
  assign ptr_up = ptr + step;
  assign ptr_dn = ptr - step;

  always_comb begin
    res.ea     = ptr;
    res.direct = 1'b0;
    res.wb_en  = 1'b0;
    res.wb_val = ptr;
    unique case (mode)
      AM_DIRECT:  res.direct = 1'b1;
      AM_IND:     ;
      AM_POSTINC: begin res.wb_en = 1'b1; res.wb_val = ptr_up; end
      AM_POSTDEC: begin res.wb_en = 1'b1; res.wb_val = ptr_dn; end
      AM_PREINC:  begin res.ea = ptr_up; res.wb_en = 1'b1; res.wb_val = ptr_up; end
      AM_PREDEC:  begin res.ea = ptr_dn; res.wb_en = 1'b1; res.wb_val = ptr_dn; end
      AM_INDEXED: res.ea = ptr + ofs;
      AM_LITOFS:  res.ea = ptr + lit_sx;
      default:    ;
    endcase
  end

  // R6
  pre_ea_is_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_PREINC || mode == AM_PREDEC) |-> (res.wb_en && res.wb_val == res.ea));

  // R5
  post_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_POSTINC) |-> (DW'(res.wb_val - res.ea) == (is_byte ? DW'(1) : DW'(2))));

  // R7
  indexed_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_INDEXED || mode == AM_LITOFS || mode == AM_IND) |-> (!res.wb_en && !res.direct));
endmodule

// File: rtl/wb_arbiter.sv
module wb_arbiter #(
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_en,
  input  logic [IW-1:0] src_idx,
  input  logic          dst_en,
  input  logic [IW-1:0] dst_idx,
  output logic          src_en_eff,
  output logic          dst_en_eff
);
  logic clash;

  assign clash      = src_en && dst_en && (src_idx == dst_idx);
  assign src_en_eff = src_en && !clash;
  assign dst_en_eff = dst_en;

  // R10
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en_eff && dst_en_eff) |-> (src_idx != dst_idx));
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_val,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_val,
  input  logic [IW-1:0] rc_idx,
  output logic [DW-1:0] rc_val,
  input  logic          hi_we,
  input  logic [IW-1:0] hi_idx,
  input  logic [DW-1:0] hi_val,
  input  logic          mid_we,
  input  logic [IW-1:0] mid_idx,
  input  logic [DW-1:0] mid_val,
  input  logic          lo_we,
  input  logic [IW-1:0] lo_idx,
  input  logic [DW-1:0] lo_val
);
  logic [NREG-1:0][DW-1:0] regs;

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];
  assign rc_val = regs[rc_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (hi_we && hi_idx == IW'(i))        regs[i] <= hi_val;
        else if (mid_we && mid_idx == IW'(i)) regs[i] <= mid_val;
        else if (lo_we && lo_idx == IW'(i))   regs[i] <= lo_val;
      end
    end
  end

  // R12
  hi_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> (regs[$past(hi_idx)] == $past(hi_val)));
endmodule

// File: rtl/move_ea_unit.sv
module move_ea_unit
  import move_ea_pkg::*;
#(
  parameter int unsigned NREG  = 16,
  parameter int unsigned LIT_W = 10,
  localparam int unsigned IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_src_mode,
  input  logic [IW-1:0] req_src_reg,
  input  logic [2:0]    req_dst_mode,
  input  logic [IW-1:0] req_dst_reg,
  input  logic [IW-1:0] req_ofs_reg,
  input  logic [LIT_W-1:0] req_lit,
  input  logic          req_byte,
  input  logic [1:0]    req_imm_kind,
  input  logic [DW-1:0] req_imm,
  input  logic          rf_we,
  input  logic [IW-1:0] rf_waddr,
  input  logic [DW-1:0] rf_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_src_ea,
  output logic [DW-1:0] rsp_dst_ea,
  output logic          rsp_src_direct,
  output logic          rsp_dst_direct,
  output logic          rsp_src_imm,
  output logic          rsp_wb_src_en,
  output logic [IW-1:0] rsp_wb_src_reg,
  output logic [DW-1:0] rsp_wb_src_val,
  output logic          rsp_wb_dst_en,
  output logic [IW-1:0] rsp_wb_dst_reg,
  output logic [DW-1:0] rsp_wb_dst_val
);
  logic          accept;
  logic [DW-1:0] src_ptr, dst_ptr, ofs_val;
  logic [DW-1:0] lit_sx;
  logic [DW-1:0] imm_val;
  logic          use_imm;
  side_res_t     src_raw, dst_res, src_res;
  logic          src_wb_ok, dst_wb_ok;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign lit_sx    = {{(DW-LIT_W){req_lit[LIT_W-1]}}, req_lit};
  assign use_imm   = (req_imm_kind != 2'd0);
  assign imm_val   = (req_imm_kind == 2'd1) ? {8'h00, req_imm[7:0]} : req_imm;

  ptr_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (req_src_reg),
    .ra_val  (src_ptr),
    .rb_idx  (req_dst_reg),
    .rb_val  (dst_ptr),
    .rc_idx  (req_ofs_reg),
    .rc_val  (ofs_val),
    .hi_we   (accept && dst_wb_ok),
    .hi_idx  (req_dst_reg),
    .hi_val  (dst_res.wb_val),
    .mid_we  (accept && src_wb_ok),
    .mid_idx (req_src_reg),
    .mid_val (src_res.wb_val),
    .lo_we   (rf_we),
    .lo_idx  (rf_waddr),
    .lo_val  (rf_wdata)
  );

  ea_side u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (amode_e'(req_src_mode)),
    .ptr     (src_ptr),
    .ofs     (ofs_val),
    .lit_sx  (lit_sx),
    .is_byte (req_byte),
    .res     (src_raw)
  );

  ea_side u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (amode_e'(req_dst_mode)),
    .ptr     (dst_ptr),
    .ofs     (ofs_val),
    .lit_sx  (lit_sx),
    .is_byte (req_byte),
    .res     (dst_res)
  );

  always_comb begin
    src_res = src_raw;
    if (use_imm) begin
      src_res.ea     = imm_val;
      src_res.direct = 1'b0;
      src_res.wb_en  = 1'b0;
    end
  end

  wb_arbiter #(.IW(IW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_res.wb_en),
    .src_idx    (req_src_reg),
    .dst_en     (dst_res.wb_en),
    .dst_idx    (req_dst_reg),
    .src_en_eff (src_wb_ok),
    .dst_en_eff (dst_wb_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_src_ea     <= '0;
      rsp_dst_ea     <= '0;
      rsp_src_direct <= 1'b0;
      rsp_dst_direct <= 1'b0;
      rsp_src_imm    <= 1'b0;
      rsp_wb_src_en  <= 1'b0;
      rsp_wb_src_reg <= '0;
      rsp_wb_src_val <= '0;
      rsp_wb_dst_en  <= 1'b0;
      rsp_wb_dst_reg <= '0;
      rsp_wb_dst_val <= '0;
    end else if (accept) begin
      rsp_valid      <= 1'b1;
      rsp_src_ea     <= src_res.ea;
      rsp_dst_ea     <= dst_res.ea;
      rsp_src_direct <= src_res.direct;
      rsp_dst_direct <= dst_res.direct;
      rsp_src_imm    <= use_imm;
      rsp_wb_src_en  <= src_wb_ok;
      rsp_wb_src_reg <= req_src_reg;
      rsp_wb_src_val <= src_res.wb_val;
      rsp_wb_dst_en  <= dst_wb_ok;
      rsp_wb_dst_reg <= req_dst_reg;
      rsp_wb_dst_val <= dst_res.wb_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_src_ea) && $stable(rsp_dst_ea)
      && $stable(rsp_wb_src_en) && $stable(rsp_wb_dst_en) && $stable(rsp_wb_dst_val)));

  // R2
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  imm_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src_imm) |-> (!rsp_wb_src_en && !rsp_src_direct));
endmodule

// File: tb/tb_move_ea_unit.sv
module tb_move_ea_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [2:0] req_src_mode = 0, req_dst_mode = 0;
  logic [3:0] req_src_reg = 0, req_dst_reg = 0, req_ofs_reg = 0;
  logic [9:0] req_lit = 0;
  logic req_byte = 0;
  logic [1:0] req_imm_kind = 0;
  logic [15:0] req_imm = 0;
  logic rf_we = 0;
  logic [3:0] rf_waddr = 0;
  logic [15:0] rf_wdata = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [15:0] rsp_src_ea, rsp_dst_ea, rsp_wb_src_val, rsp_wb_dst_val;
  logic rsp_src_direct, rsp_dst_direct, rsp_src_imm, rsp_wb_src_en, rsp_wb_dst_en;
  logic [3:0] rsp_wb_src_reg, rsp_wb_dst_reg;

  move_ea_unit dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] m [16];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void side(input logic [2:0] md, input logic [15:0] p, input logic [15:0] ofs,
                               input logic [15:0] lsx, input logic byt, output logic [15:0] ea,
                               output logic d, output logic we, output logic [15:0] wv);
    logic [15:0] st = byt ? 16'd1 : 16'd2;
    ea = p; d = 0; we = 0; wv = p;
    case (md)
      3'd0: d = 1;
      3'd2: begin we = 1; wv = p + st; end
      3'd3: begin we = 1; wv = p - st; end
      3'd4: begin ea = p + st; we = 1; wv = ea; end
      3'd5: begin ea = p - st; we = 1; wv = ea; end
      3'd6: ea = p + ofs;
      3'd7: ea = p + lsx;
      default: ;
    endcase
  endfunction

  task automatic xact(input logic [2:0] sm, input logic [3:0] sr, input logic [2:0] dm,
                      input logic [3:0] dr, input logic [3:0] orr, input logic [9:0] lit,
                      input logic byt, input logic [1:0] ik, input logic [15:0] imm, input int hold);
    logic [15:0] lsx, sea, dea, swv, dwv, sdea;
    logic sd, dd, swe, dwe;
    lsx = {{6{lit[9]}}, lit};
    side(sm, m[sr], m[orr], lsx, byt, sea, sd, swe, swv);
    side(dm, m[dr], m[orr], lsx, byt, dea, dd, dwe, dwv);
    if (ik != 0) begin sea = (ik == 1) ? {8'h00, imm[7:0]} : imm; sd = 0; swe = 0; end
    if (swe && dwe && sr == dr) swe = 0;
    @(negedge clk);
    req_src_mode = sm; req_src_reg = sr; req_dst_mode = dm; req_dst_reg = dr;
    req_ofs_reg = orr; req_lit = lit; req_byte = byt; req_imm_kind = ik; req_imm = imm;
    req_valid = 1; rsp_ready = 0;
    chk("R2 ready when empty", 16'(req_ready), 16'd1);
    @(negedge clk);
    req_valid = 0;
    chk("R2 rsp_valid", 16'(rsp_valid), 16'd1);
    chk("R3-src ea mode", rsp_src_ea, sea);
    chk("R4-dst ea mode", rsp_dst_ea, dea);
    chk("R3 src direct", 16'(rsp_src_direct), 16'(sd));
    chk("R3 dst direct", 16'(rsp_dst_direct), 16'(dd));
    chk("R9 src imm", 16'(rsp_src_imm), 16'(ik != 0));
    chk("R10 src wb en", 16'(rsp_wb_src_en), 16'(swe));
    chk("R5 dst wb en", 16'(rsp_wb_dst_en), 16'(dwe));
    if (swe) chk("R6 src wb val", rsp_wb_src_val, swv);
    if (dwe) chk("R6 dst wb val", rsp_wb_dst_val, dwv);
    sdea = rsp_dst_ea;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R2 held valid", 16'(rsp_valid), 16'd1);
      chk("R2 stalled ready", 16'(req_ready), 16'd0);
      chk("R2 held dst ea", rsp_dst_ea, sdea);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R2 drained", 16'(rsp_valid), 16'd0);
    rsp_ready = 0;
    if (swe) m[sr] = swv;
    if (dwe) m[dr] = dwv;
  endtask

  task automatic peek(input logic [3:0] r, input string tag);
    @(negedge clk);
    req_src_mode = 0; req_src_reg = r; req_dst_mode = 0; req_dst_reg = r;
    req_imm_kind = 0; req_valid = 1; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(tag, rsp_src_ea, m[r]);
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    rf_we = 1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 0;
    m[a] = d;
  endtask

  initial begin
    int unsigned seed = 32'h5eed1234;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 16'(rsp_valid), 16'd0);
    chk("R1 req_ready", 16'(req_ready), 16'd1);
    rst_n = 1;
    peek(4'd9, "R1 reg zero");
    // R12 plain write then read
    wr(4'd5, 16'h1234);
    peek(4'd5, "R12 write port");
    // directed modes
    wr(4'd3, 16'd100); wr(4'd4, 16'd40);
    xact(3'd2, 4'd3, 3'd3, 4'd4, 0, 0, 0, 0, 0, 2);   // R5 word post
    xact(3'd4, 4'd3, 3'd5, 4'd4, 0, 0, 1, 0, 0, 1);   // R6 byte pre
    xact(3'd6, 4'd3, 3'd6, 4'd4, 4'd5, 0, 0, 0, 0, 0); // R7 both indexed
    xact(3'd7, 4'd3, 3'd7, 4'd4, 0, 10'h3F0, 0, 0, 0, 0); // R8 negative literal
    xact(3'd2, 4'd3, 3'd1, 4'd4, 0, 0, 0, 2'd1, 16'hABCD, 0); // R9 8-bit imm
    xact(3'd2, 4'd3, 3'd0, 4'd4, 0, 0, 0, 2'd2, 16'hABCD, 0); // R9 16-bit imm
    xact(3'd2, 4'd3, 3'd3, 4'd3, 0, 0, 0, 0, 0, 0);   // R10 same reg, dst wins
    peek(4'd3, "R10 dst update kept");
    // R11 back-to-back pointer reuse
    wr(4'd7, 16'd200);
    @(negedge clk);
    req_src_mode = 3'd2; req_src_reg = 4'd7; req_dst_mode = 3'd0; req_dst_reg = 4'd0;
    req_imm_kind = 0; req_byte = 0; req_valid = 1; rsp_ready = 1;
    @(negedge clk);
    chk("R11 first ea", rsp_src_ea, 16'd200);
    req_src_mode = 3'd1;
    @(negedge clk);
    req_valid = 0;
    chk("R11 second sees update", rsp_src_ea, 16'd202);
    m[7] = 16'd202;
    @(negedge clk);
    rsp_ready = 0;
    // R12 collision: pointer update beats write port
    @(negedge clk);
    req_src_mode = 3'd1; req_src_reg = 4'd0; req_dst_mode = 3'd2; req_dst_reg = 4'd7;
    req_valid = 1; rsp_ready = 1; rf_we = 1; rf_waddr = 4'd7; rf_wdata = 16'd999;
    @(negedge clk);
    req_valid = 0; rf_we = 0;
    m[7] = 16'd204;
    @(negedge clk);
    rsp_ready = 0;
    peek(4'd7, "R12 pointer update wins");
    // random
    for (int i = 0; i < 16; i++) wr(4'(i), 16'($urandom));
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ik;
      ik = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      xact(3'($urandom), 4'($urandom), 3'($urandom), 4'($urandom), 4'($urandom),
           10'($urandom), 1'($urandom), ik, 16'($urandom), int'($urandom % 3));
    end
    for (int i = 0; i < 16; i++) peek(4'(i), "R11 final regs");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule